// File: doc/BRIEF.md
# Masked Multi-Level Interrupt Concentrator

This block gathers thirteen level-sensitive interrupt lines from peripherals into a 32-bit pending register. Each line owns one fixed bit in that register, and the bits are not contiguous. A 32-bit enable register selects which pending bits may interrupt the processor. The block reduces the enabled pending bits to a 3-bit processor priority level. Every source belongs to one of three groups, at levels 3, 5 and 6. The output is the highest group that has an enabled pending bit, or 0 when no group has one.

Software reaches both registers over a simple 32-bit register bus. Writes are strobed and reads are combinational. The pending register can be overwritten directly, and while a line is held it sets its own bit again. One extra input is a write strobe for a peripheral control byte. Bit 4 of that byte requests the storage-DMA interrupt in software.

Top module: `irq_concentrator`

## Requirements
- R1: After reset the pending register, the enable register and `level_o` are all zero.
- R2: The pending register is at byte offset 0x7000 and the enable register is at 0x7800. Both are 32 bits wide. A read at any other offset returns 0, and a write to any other offset changes neither register.
- R3: The level-3 sources map to pending bits as follows: `irq_i[0]`→7, `irq_i[1]`→3, `irq_i[2]`→2, `irq_i[3]`→9, `irq_i[4]`→10, `irq_i[5]`→12 and `irq_i[6]`→5.
- R4: The level-5 source `irq_i[7]` maps to pending bit 17.
- R5: The level-6 sources map to pending bits as follows: `irq_i[8]`→28, `irq_i[9]`→27, `irq_i[10]`→26, `irq_i[11]`→23 and `irq_i[12]`→21.
- R6: Outside a pending-register write, each mapped bit follows its line one clock later. A high line sets the bit and a low line clears it.
- R7: A control-byte write with `ctl_data[4]`=1 makes pending bit 26 read 1 from the next clock on. A later control-byte write with `ctl_data[4]`=0 lets bit 26 fall back to the level of `irq_i[10]`.
- R8: A pending-register write takes effect on the next clock, with every asserted line ORed into its bit on that same clock. Unmapped bits keep the written value until the next write.
- R9: An enable bit of 1 lets its pending bit take part. The level is 6, 5 or 3 for the highest group that has an enabled pending bit, and 0 when none has one. Unmapped bits never raise the level.
- R10: `level_o` is registered. It changes one clock after the pending or enable register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 13 | Level-sensitive source lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| ctl_we | input | 1 | Control-byte write strobe |
| ctl_data | input | 8 | Control byte; bit 4 requests the storage-DMA interrupt |
| level_o | output | 3 | Processor priority level |

## Verification
The directed tests raise one source from each group on its own under a full enable mask. This separates a wrong bit position from a wrong group, and it places the registered level one clock behind the pending bit. Further directed cases clear the mask, enable only an unmapped bit, write to an unused offset, and write the pending register while a line is held. These tell a missing enable from a missing OR-back of lines, and they show whether unmapped bits hold. A seeded random phase mixes line toggles, register writes and control-byte writes at random offsets. It compares every register and the level each cycle against a reference model, which catches mistakes in the ordering between software writes and line updates.

// File: rtl/irq_concentrator.sv
module irq_concentrator #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [AW-1:0] PEND_OFS = 16'h7000,
  parameter logic [AW-1:0] EN_OFS = 16'h7800,
  parameter int CTL_DMA_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [12:0]   irq_i,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_data,
  output logic [2:0]    level_o
);
  localparam int NSRC = 13;
  localparam int DMA_SRC = 10;
  localparam int POS [NSRC] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};
  localparam int GRP [NSRC] = '{3, 3, 3, 3, 3, 3, 3, 5, 6, 6, 6, 6, 6};

  function automatic logic [DW-1:0] group_bits(input int g);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++)
      if (GRP[i] == g) m[POS[i]] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] G3 = group_bits(3);
  localparam logic [DW-1:0] G5 = group_bits(5);
  localparam logic [DW-1:0] G6 = group_bits(6);
  localparam logic [DW-1:0] TRACKED = G3 | G5 | G6;

  logic [DW-1:0] status_q, mask_q, live, active;
  logic          dma_flag_q, dma_eff;
  logic [2:0]    level_d;

  assign dma_eff = ctl_we ? ctl_data[CTL_DMA_BIT] : dma_flag_q;

  always_comb begin
    live = '0;
    for (int i = 0; i < NSRC; i++) live[POS[i]] = irq_i[i];
    live[POS[DMA_SRC]] = irq_i[DMA_SRC] | dma_eff;
  end

  assign active  = status_q & mask_q;
  assign level_d = |(active & G6) ? 3'd6 :
                   |(active & G5) ? 3'd5 :
                   |(active & G3) ? 3'd3 : 3'd0;

  assign reg_rdata = (reg_addr == PEND_OFS) ? status_q :
                     (reg_addr == EN_OFS)   ? mask_q   : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= '0;
      mask_q     <= '0;
      dma_flag_q <= 1'b0;
      level_o    <= 3'd0;
    end else begin
      if (reg_we && reg_addr == PEND_OFS) status_q <= reg_wdata | live;
      else                                status_q <= (status_q & ~TRACKED) | live;
      if (reg_we && reg_addr == EN_OFS) mask_q <= reg_wdata;
      if (ctl_we) dma_flag_q <= ctl_data[CTL_DMA_BIT];
      level_o <= level_d;
    end
  end
endmodule

module irq_concentrator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] irq_i,
  input logic        reg_we,
  input logic [15:0] reg_addr,
  input logic [31:0] reg_wdata,
  input logic        ctl_we,
  input logic [7:0]  ctl_data,
  input logic [31:0] status_q,
  input logic [31:0] mask_q,
  input logic [2:0]  level_o
);
  // R3
  scsi_line_sets_bit12_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i[5] |=> status_q[12]);
  // R4
  serial_line_sets_bit17_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i[7] |=> status_q[17]);
  // R5
  etx_dma_line_sets_bit28_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i[8] |=> status_q[28]);
  // R7
  ctl_dma_sets_bit26_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_data[4]) |=> status_q[26]);
  // R2
  enable_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 16'h7800) |=> mask_q == $past(reg_wdata));
  // R8
  unmapped_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 16'h7000) |=> (status_q & ~32'h1CA216AC) == $past(status_q & ~32'h1CA216AC));
  // R10
  level_six_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & mask_q & 32'h1CA00000)) |=> level_o == 3'd6);
  // R9
  level_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_o inside {3'd0, 3'd3, 3'd5, 3'd6});
endmodule

bind irq_concentrator irq_concentrator_chk u_chk (.*);

// File: tb/tb_irq_concentrator.sv
`timescale 1ns/1ps
module tb_irq_concentrator;
  logic        clk = 0, rst_n = 0;
  logic [12:0] irq_i = '0;
  logic        reg_we = 0, ctl_we = 0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0]  ctl_data = '0;
  logic [2:0]  level_o;
  int n_chk = 0, n_bad = 0;
  logic [31:0] m_st = 0, m_mk = 0;
  logic        m_fl = 0;
  logic [2:0]  m_lv = 0;
  localparam int POS [13] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};
  localparam logic [31:0] TRK = 32'h1CA216AC;

  irq_concentrator dut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] live_of(input logic [12:0] l, input logic fl);
    logic [31:0] v = '0;
    for (int i = 0; i < 13; i++) v[POS[i]] = l[i];
    v[26] = v[26] | fl;
    return v;
  endfunction

  function automatic logic [2:0] lvl_of(input logic [31:0] s, input logic [31:0] m);
    logic [31:0] a = s & m;
    if (|(a & 32'h1CA00000)) return 3'd6;
    if (|(a & 32'h00020000)) return 3'd5;
    if (|(a & 32'h000016AC)) return 3'd3;
    return 3'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [12:0] l, input logic we, input logic [15:0] a,
                      input logic [31:0] d, input logic cwe, input logic [7:0] cd);
    logic [31:0] lv, n_st, n_mk;
    logic n_fl;
    @(negedge clk);
    irq_i = l; reg_we = we; reg_addr = a; reg_wdata = d; ctl_we = cwe; ctl_data = cd;
    lv = live_of(l, cwe ? cd[4] : m_fl);
    n_st = (we && a == 16'h7000) ? (d | lv) : ((m_st & ~TRK) | lv);
    n_mk = (we && a == 16'h7800) ? d : m_mk;
    n_fl = cwe ? cd[4] : m_fl;
    @(posedge clk);
    #1;
    m_lv = lvl_of(m_st, m_mk);
    m_st = n_st; m_mk = n_mk; m_fl = n_fl;
    reg_we = 0; ctl_we = 0;
  endtask

  task automatic check_all(input string tag);
    reg_addr = 16'h7000; #1 chk({tag, " pending"}, reg_rdata, m_st);
    reg_addr = 16'h7800; #1 chk({tag, " enable"}, reg_rdata, m_mk);
    chk({tag, " level"}, {29'd0, level_o}, {29'd0, m_lv});
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #45 rst_n = 1;
    // R1
    reg_addr = 16'h7000; #1 chk("R1 pending", reg_rdata, 0);
    reg_addr = 16'h7800; #1 chk("R1 enable", reg_rdata, 0);
    chk("R1 level", {29'd0, level_o}, 0);
    // R2: enable all, read back
    step('0, 1, 16'h7800, 32'hFFFF_FFFF, 0, 0); check_all("R2");
    // R3 and R10: floppy line
    step(13'h0001, 0, 0, 0, 0, 0);
    chk("R3 bit7", reg_rdata & 32'h80, 0);
    reg_addr = 16'h7000; #1 chk("R3 bit7", reg_rdata, 32'h80);
    chk("R10 level lags", {29'd0, level_o}, 0);
    step(13'h0001, 0, 0, 0, 0, 0);
    chk("R10 level", {29'd0, level_o}, 3);
    // R4
    step(13'h0080, 0, 0, 0, 0, 0); step(13'h0080, 0, 0, 0, 0, 0);
    reg_addr = 16'h7000; #1 chk("R4 bit17", reg_rdata, 32'h20000);
    chk("R4 level", {29'd0, level_o}, 5);
    // R5
    step(13'h0800, 0, 0, 0, 0, 0); step(13'h0800, 0, 0, 0, 0, 0);
    reg_addr = 16'h7000; #1 chk("R5 bit23", reg_rdata, 32'h800000);
    chk("R5 level", {29'd0, level_o}, 6);
    // R6
    step('0, 0, 0, 0, 0, 0);
    reg_addr = 16'h7000; #1 chk("R6 cleared", reg_rdata, 0);
    // R7
    step('0, 0, 0, 0, 1, 8'h10);
    reg_addr = 16'h7000; #1 chk("R7 set", reg_rdata, 32'h4000000);
    step('0, 0, 0, 0, 0, 0);
    reg_addr = 16'h7000; #1 chk("R7 held", reg_rdata, 32'h4000000);
    step('0, 0, 0, 0, 1, 8'hEF);
    reg_addr = 16'h7000; #1 chk("R7 clear", reg_rdata, 0);
    // R8
    step(13'h0002, 1, 16'h7000, 32'h0000_0001, 0, 0);
    reg_addr = 16'h7000; #1 chk("R8 write or line", reg_rdata, 32'h9);
    step('0, 0, 0, 0, 0, 0);
    reg_addr = 16'h7000; #1 chk("R8 unmapped holds", reg_rdata, 32'h1);
    // R9
    step('0, 1, 16'h7800, 32'h1, 0, 0); step('0, 0, 0, 0, 0, 0);
    chk("R9 unmapped no level", {29'd0, level_o}, 0);
    step(13'h0004, 1, 16'h7800, 32'h0, 0, 0); step(13'h0004, 0, 0, 0, 0, 0);
    chk("R9 masked", {29'd0, level_o}, 0);
    step(13'h0004, 1, 16'h7800, 32'h4, 0, 0); step(13'h0004, 0, 0, 0, 0, 0);
    chk("R9 enabled", {29'd0, level_o}, 3);
    // R2: unused offset
    step('0, 1, 16'h7004, 32'hDEAD_BEEF, 0, 0);
    reg_addr = 16'h7004; #1 chk("R2 unused read", reg_rdata, 0);
    check_all("R2 unused write");
    // random phase: R6 R8 R9 R10
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a;
      int sel = $urandom_range(0, 3);
      a = (sel == 0) ? 16'h7000 : (sel == 1) ? 16'h7800 : (sel == 2) ? 16'h7004 : 16'($urandom);
      step(13'($urandom), ($urandom_range(0, 7) == 0), a, $urandom,
           ($urandom_range(0, 9) == 0), 8'($urandom));
      check_all("R8 R9 R10 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule